// File: doc/BRIEF.md
# Serial flash erase sequencer

This block runs a complete erase of a serial NOR flash device through a byte-level SPI master. One request names a range of sectors by first and last index, or sets a whole-device flag. For every erase it builds three chip-select frames in turn. The first is a lone write-enable instruction. The second is the erase instruction: a sector erase carries a three-byte address, while a chip erase carries no address. The third is a status poll that reads status bytes until the busy bit clears or a poll budget runs out.

When the range covers the whole device and the two erase opcodes differ, the block tries a single chip erase first. It uses a budget ten times larger than the per-sector budget. If that chip erase times out, the block falls back to erasing the sectors one by one. A sector that times out ends the request with an error. A malformed range is refused before any frame is opened.

The SPI master below this block moves one byte per request/acknowledge handshake. It holds the frame open for as long as chip select is high. The byte returned by the device is valid in the acknowledge cycle.

Top module: `fer_erase_seq`

## Requirements
- R1: During and after reset, and before any request, spi_cs_o, spi_req_o, done_o and err_o are all low.
- R2: Every erase frame is preceded by a frame that holds exactly one byte, the write-enable opcode 0x06.
- R3: A sector-erase frame is the sector-erase opcode followed by three address bytes, most significant first, equal to sector index times SECTOR_BYTES; spi_tx_o stays stable while a byte request waits for its acknowledge.
- R4: When the effective range is 0 to NUM_SECTORS-1 and the chip-erase opcode differs from the sector-erase opcode, a single chip-erase frame holding only the chip-erase opcode is sent, and its poll budget is CHIP_POLL_LIMIT status bytes.
- R5: A status frame is opcode 0x05 followed by dummy bytes 0x00; each dummy byte returns one status byte, and only bit 0 (1 = busy) is used. The frame ends on the first status byte whose bit 0 is 0.
- R6: After a busy status byte, spi_req_o stays low for exactly poll_gap_i+1 cycles before the next dummy byte is requested.
- R7: A status frame that has read its budget of busy bytes (SECT_POLL_LIMIT for a sector) closes at once; for a sector erase the request ends with err_o high and no further frame.
- R8: If the chip erase times out, the block erases sectors 0 to NUM_SECTORS-1 in ascending order. If they all succeed, the request ends without error.
- R9: A range first..last is erased one sector at a time in ascending order, each as write-enable, sector-erase and status frames.
- R10: A request with last < first or last >= NUM_SECTORS (whole_i low) produces done_o and err_o in the cycle after start_i is sampled, and opens no frame.
- R11: done_o is a one-cycle pulse per request. err_o is high only together with done_o and is low on success.
- R12: start_i is ignored while a request is in progress. It does not change the frames sent or the result.
- R13: With whole_i high, first_i and last_i are ignored and the effective range is the whole device.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request pulse, sampled while idle |
| whole_i | input | 1 | Erase the whole device regardless of range |
| first_i | input | IDX_W | First sector index of the range |
| last_i | input | IDX_W | Last sector index of the range |
| poll_gap_i | input | GAP_W | Idle cycles between status polls, minus one |
| spi_cs_o | output | 1 | Frame open (chip select active) |
| spi_req_o | output | 1 | Byte transfer request |
| spi_tx_o | output | 8 | Byte to shift out |
| spi_ack_i | input | 1 | Byte transfer complete |
| spi_rx_i | input | 8 | Byte shifted in, valid with spi_ack_i |
| done_o | output | 1 | Request finished, one-cycle pulse |
| err_o | output | 1 | Request failed, valid with done_o |

## Verification
The bench plays the flash device and plans how many busy statuses each poll frame returns. A single mid-range sector separates address formation and frame order from range handling. A multi-sector range with mixed busy counts separates per-sector polling from the ascending walk. A full range whose chip poll succeeds is contrasted with one whose chip poll exhausts its budget, so the chip-first choice and the fallback to sectors are each seen on their own. A sector that runs out of budget in mid-range, malformed ranges, a poll gap of zero versus three, a second start during a request, and ready bytes with bit 1 still set tell apart the abort path, immediate rejection, interval counting, request locking and busy-bit decoding.

// File: rtl/fer_pkg.sv
package fer_pkg;
    localparam int ADDR_BYTES = 3;
    localparam int ADDR_W     = 8 * ADDR_BYTES;

    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_DUMMY = 8'h00;

    typedef enum logic [1:0] {
        FRM_WREN = 2'd0,
        FRM_SECT = 2'd1,
        FRM_CHIP = 2'd2,
        FRM_STAT = 2'd3
    } frm_kind_e;
endpackage

// File: rtl/fer_poll_timer.sv
module fer_poll_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         expired_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } tmr_s;

    tmr_s d, q;

    always_comb begin
        d = q;
        if (load_i) begin
            d.cnt = val_i;
        end else if (q.cnt != '0) begin
            d.cnt = q.cnt - W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign expired_o = (q.cnt == '0);

    // R6: the interval starts from the requested gap
    p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (q.cnt == $past(val_i)));

    // R6: one step per cycle towards zero
    p_count_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && q.cnt != '0) |=> (q.cnt == $past(q.cnt) - W'(1)));
endmodule

// File: rtl/fer_frame_engine.sv
module fer_frame_engine
    import fer_pkg::*;
#(
    parameter int GAP_W = 16,
    parameter int LIM_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    input  frm_kind_e         kind_i,
    input  logic [7:0]        op_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [LIM_W-1:0]  limit_i,
    input  logic [GAP_W-1:0]  gap_i,
    output logic              cs_o,
    output logic              req_o,
    output logic [7:0]        tx_o,
    input  logic              ack_i,
    input  logic [7:0]        rx_i,
    output logic              fin_o,
    output logic              fail_o
);
    typedef enum logic [1:0] {E_IDLE, E_SEND, E_WAIT} eng_st_e;

    typedef struct packed {
        eng_st_e            st;
        frm_kind_e          kind;
        logic [7:0]         op;
        logic [ADDR_W-1:0]  addr;
        logic [LIM_W-1:0]   limit;
        logic [LIM_W-1:0]   busy;
        logic [1:0]         idx;
        logic               cs;
        logic               req;
        logic               fin;
        logic               fail;
    } eng_s;

    eng_s d, q;
    logic [7:0] tx_byte;
    logic       last_byte;
    logic       tmr_load;
    logic       tmr_expired;
    logic       unused_status_bits;

    assign unused_status_bits = ^rx_i[7:1];

    // byte selection for the current position in the frame
    always_comb begin
        tx_byte   = OP_DUMMY;
        last_byte = 1'b0;
        case (q.kind)
            FRM_WREN: begin
                tx_byte   = OP_WREN;
                last_byte = 1'b1;
            end
            FRM_CHIP: begin
                tx_byte   = q.op;
                last_byte = 1'b1;
            end
            FRM_SECT: begin
                if (q.idx == 2'd0) tx_byte = q.op;
                else tx_byte = 8'(q.addr >> (8 * (ADDR_BYTES - int'(q.idx))));
                last_byte = (int'(q.idx) == ADDR_BYTES);
            end
            default: begin
                tx_byte   = (q.idx == 2'd0) ? OP_RDSR : OP_DUMMY;
                last_byte = 1'b0;
            end
        endcase
    end

    always_comb begin
        d        = q;
        d.fin    = 1'b0;
        d.fail   = 1'b0;
        tmr_load = 1'b0;
        case (q.st)
            E_IDLE: begin
                if (go_i) begin
                    d.st    = E_SEND;
                    d.kind  = kind_i;
                    d.op    = op_i;
                    d.addr  = addr_i;
                    d.limit = limit_i;
                    d.busy  = '0;
                    d.idx   = 2'd0;
                    d.cs    = 1'b1;
                    d.req   = 1'b1;
                end
            end
            E_SEND: begin
                if (!q.req) begin
                    d.req = 1'b1;
                end else if (ack_i) begin
                    d.req = 1'b0;
                    if (q.kind == FRM_STAT && q.idx != 2'd0) begin
                        if (!rx_i[0]) begin
                            d.st  = E_IDLE;
                            d.cs  = 1'b0;
                            d.fin = 1'b1;
                        end else if ((q.busy + LIM_W'(1)) == q.limit) begin
                            d.st   = E_IDLE;
                            d.cs   = 1'b0;
                            d.fin  = 1'b1;
                            d.fail = 1'b1;
                        end else begin
                            d.busy   = q.busy + LIM_W'(1);
                            d.st     = E_WAIT;
                            tmr_load = 1'b1;
                        end
                    end else if (last_byte) begin
                        d.st  = E_IDLE;
                        d.cs  = 1'b0;
                        d.fin = 1'b1;
                    end else begin
                        d.idx = q.idx + 2'd1;
                    end
                end
            end
            E_WAIT: begin
                if (tmr_expired) begin
                    d.st  = E_SEND;
                    d.req = 1'b1;
                end
            end
            default: d.st = E_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    fer_poll_timer #(.W(GAP_W)) gap_tmr_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .val_i     (gap_i),
        .expired_o (tmr_expired)
    );

    assign cs_o   = q.cs;
    assign req_o  = q.req;
    assign tx_o   = tx_byte;
    assign fin_o  = q.fin;
    assign fail_o = q.fail;

    // R5: bytes move only inside an open frame
    p_req_in_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> cs_o);

    // R3: a waiting byte and its request hold until acknowledged
    p_tx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !ack_i) |=> (req_o && $stable(tx_o)));

    // R7: the busy count never reaches the budget inside a frame
    p_busy_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != E_IDLE && q.kind == FRM_STAT) |-> (q.busy < q.limit));

    // R7: a timeout closes the frame in the same step
    p_fail_closes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |-> (fin_o && !cs_o));
endmodule

// File: rtl/fer_erase_seq.sv
module fer_erase_seq
    import fer_pkg::*;
#(
    parameter int         NUM_SECTORS     = 1024,
    parameter int         SECTOR_BYTES    = 4096,
    parameter logic [7:0] SECT_OP         = 8'h20,
    parameter logic [7:0] CHIP_OP         = 8'hC7,
    parameter int         SECT_POLL_LIMIT = 1000,
    parameter int         CHIP_POLL_LIMIT = 10000,
    parameter int         GAP_W           = 16,
    localparam int        IDX_W           = $clog2(NUM_SECTORS) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             whole_i,
    input  logic [IDX_W-1:0] first_i,
    input  logic [IDX_W-1:0] last_i,
    input  logic [GAP_W-1:0] poll_gap_i,
    output logic             spi_cs_o,
    output logic             spi_req_o,
    output logic [7:0]       spi_tx_o,
    input  logic             spi_ack_i,
    input  logic [7:0]       spi_rx_i,
    output logic             done_o,
    output logic             err_o
);
    localparam int   LIM_MAX  = (CHIP_POLL_LIMIT > SECT_POLL_LIMIT) ? CHIP_POLL_LIMIT : SECT_POLL_LIMIT;
    localparam int   LIM_W    = $clog2(LIM_MAX + 1);
    localparam logic CHIP_DIF = (CHIP_OP != SECT_OP);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SECTORS - 1);

    typedef enum logic [1:0] {T_IDLE, T_WREN, T_ERASE, T_POLL} top_st_e;

    typedef struct packed {
        top_st_e          st;
        logic             go;
        logic             chip;
        logic [IDX_W-1:0] cur;
        logic [IDX_W-1:0] last;
        logic             done;
        logic             err;
    } top_s;

    top_s d, q;

    logic              bad_range;
    logic [IDX_W-1:0]  eff_first;
    logic [IDX_W-1:0]  eff_last;
    frm_kind_e         f_kind;
    logic [7:0]        f_op;
    logic [ADDR_W-1:0] f_addr;
    logic [LIM_W-1:0]  f_limit;
    logic              f_fin;
    logic              f_fail;

    assign bad_range = !whole_i && ((last_i < first_i) || (last_i > LAST_IDX));
    assign eff_first = whole_i ? '0 : first_i;
    assign eff_last  = whole_i ? LAST_IDX : last_i;

    // frame descriptor for the engine
    always_comb begin
        case (q.st)
            T_WREN:  f_kind = FRM_WREN;
            T_ERASE: f_kind = q.chip ? FRM_CHIP : FRM_SECT;
            default: f_kind = FRM_STAT;
        endcase
        f_op    = q.chip ? CHIP_OP : SECT_OP;
        f_addr  = ADDR_W'(32'(q.cur) * 32'(SECTOR_BYTES));
        f_limit = q.chip ? LIM_W'(CHIP_POLL_LIMIT) : LIM_W'(SECT_POLL_LIMIT);
    end

    always_comb begin
        d      = q;
        d.go   = 1'b0;
        d.done = 1'b0;
        d.err  = 1'b0;
        case (q.st)
            T_IDLE: begin
                if (start_i) begin
                    if (bad_range) begin
                        d.done = 1'b1;
                        d.err  = 1'b1;
                    end else begin
                        d.chip = CHIP_DIF && (eff_first == '0) && (eff_last == LAST_IDX);
                        d.cur  = eff_first;
                        d.last = eff_last;
                        d.st   = T_WREN;
                        d.go   = 1'b1;
                    end
                end
            end
            T_WREN: begin
                if (f_fin) begin
                    d.st = T_ERASE;
                    d.go = 1'b1;
                end
            end
            T_ERASE: begin
                if (f_fin) begin
                    d.st = T_POLL;
                    d.go = 1'b1;
                end
            end
            T_POLL: begin
                if (f_fin) begin
                    if (f_fail) begin
                        if (q.chip) begin
                            d.chip = 1'b0;
                            d.cur  = '0;
                            d.st   = T_WREN;
                            d.go   = 1'b1;
                        end else begin
                            d.st   = T_IDLE;
                            d.done = 1'b1;
                            d.err  = 1'b1;
                        end
                    end else if (q.chip || q.cur == q.last) begin
                        d.st   = T_IDLE;
                        d.done = 1'b1;
                    end else begin
                        d.cur = q.cur + IDX_W'(1);
                        d.st  = T_WREN;
                        d.go  = 1'b1;
                    end
                end
            end
            default: d.st = T_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    fer_frame_engine #(.GAP_W(GAP_W), .LIM_W(LIM_W)) eng_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .go_i    (q.go),
        .kind_i  (f_kind),
        .op_i    (f_op),
        .addr_i  (f_addr),
        .limit_i (f_limit),
        .gap_i   (poll_gap_i),
        .cs_o    (spi_cs_o),
        .req_o   (spi_req_o),
        .tx_o    (spi_tx_o),
        .ack_i   (spi_ack_i),
        .rx_i    (spi_rx_i),
        .fin_o   (f_fin),
        .fail_o  (f_fail)
    );

    assign done_o = q.done;
    assign err_o  = q.err;

    // R11: completion is a single-cycle pulse
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R11: error is only reported alongside completion
    p_err_with_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> done_o);

    // R10: malformed ranges are refused on the next cycle
    p_reject_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == T_IDLE && start_i && bad_range) |=> (done_o && err_o));

    // R10: no frame is open while the sequencer is idle
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == T_IDLE) |-> !spi_cs_o);

    // R12: a request in progress keeps its range
    p_range_locked_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != T_IDLE && !(q.st == T_POLL && f_fin)) |=> $stable(q.last));
endmodule

// File: tb/fer_erase_seq_tb_top.sv
`timescale 1ns/1ps
module fer_erase_seq_tb_top;
    localparam int NSEC = 8;
    localparam int SB   = 4096;
    localparam int SP   = 5;
    localparam int CP   = 50;
    localparam int IW   = $clog2(NSEC) + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          whole_i = 1'b0;
    logic [IW-1:0] first_i = '0;
    logic [IW-1:0] last_i = '0;
    logic [15:0]   poll_gap_i = 16'd3;
    logic          spi_cs_o, spi_req_o, done_o, err_o;
    logic [7:0]    spi_tx_o;
    logic          spi_ack_i = 1'b0;
    logic [7:0]    spi_rx_i = 8'h00;

    int vecs = 0;
    int fails = 0;
    bit finished = 0;

    logic [8:0] obs[$];
    logic [8:0] expq[$];
    int plan_q[$];
    int busy_plan[$];

    bit prev_cs = 0, prev_done = 0, in_stat = 0, measuring = 0;
    int pos = 0, busy_left = 0, gap_cnt = 0, cur_gap = 3;

    always #2.5 clk = ~clk;

    fer_erase_seq #(
        .NUM_SECTORS(NSEC), .SECTOR_BYTES(SB), .SECT_OP(8'h20), .CHIP_OP(8'hC7),
        .SECT_POLL_LIMIT(SP), .CHIP_POLL_LIMIT(CP), .GAP_W(16)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .whole_i(whole_i),
        .first_i(first_i), .last_i(last_i), .poll_gap_i(poll_gap_i),
        .spi_cs_o(spi_cs_o), .spi_req_o(spi_req_o), .spi_tx_o(spi_tx_o),
        .spi_ack_i(spi_ack_i), .spi_rx_i(spi_rx_i), .done_o(done_o), .err_o(err_o)
    );

    task automatic chk(input bit ok, input string rq, input string what, input int act, input int ex);
        vecs++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, ex);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
            $finish;
        end
    endtask

    // flash device model and per-clock protocol comparison
    always @(negedge clk) begin
        if (!rst_n) begin
            spi_ack_i = 1'b0; prev_cs = 0; pos = 0; in_stat = 0; measuring = 0; prev_done = 0;
        end else begin
            chk(!(err_o && !done_o), "R11", "err without done", int'(err_o), 0);
            chk(!(done_o && prev_done), "R11", "done longer than one cycle", int'(done_o), 0);
            chk(!(spi_req_o && !spi_cs_o), "R5", "byte request outside frame", int'(spi_req_o), 0);
            prev_done = done_o;
            if (prev_cs && !spi_cs_o) begin
                obs.push_back(9'h100); pos = 0; in_stat = 0; measuring = 0;
            end
            if (measuring) begin
                if (!spi_cs_o) measuring = 0;
                else if (!spi_req_o) gap_cnt++;
                else begin
                    chk(gap_cnt == cur_gap + 1, "R6", "poll gap cycles", gap_cnt, cur_gap + 1);
                    measuring = 0;
                end
            end
            if (spi_ack_i) begin
                spi_ack_i = 1'b0;
            end else if (spi_req_o && spi_cs_o) begin
                obs.push_back({1'b0, spi_tx_o});
                if (pos == 0 && spi_tx_o == 8'h05) begin
                    in_stat = 1;
                    busy_left = (busy_plan.size() > 0) ? busy_plan.pop_front() : 0;
                end else if (in_stat) begin
                    if (busy_left > 0) begin
                        spi_rx_i = 8'h03; busy_left--; measuring = 1; gap_cnt = 0;
                    end else begin
                        spi_rx_i = 8'h02;
                    end
                end
                pos++;
                spi_ack_i = 1'b1;
            end
            prev_cs = spi_cs_o;
        end
    end

    task automatic push_stat(input int b, input int lim);
        int n;
        expq.push_back(9'h005);
        n = (b < lim) ? b + 1 : lim;
        for (int i = 0; i < n; i++) expq.push_back(9'h000);
        expq.push_back(9'h100);
    endtask

    task automatic build_exp(input bit whole, input int f, input int l, output bit e_err);
        int k = 0;
        int b;
        int a;
        expq.delete();
        e_err = 0;
        if (!whole && (l < f || l >= NSEC)) begin e_err = 1; return; end
        if (whole) begin f = 0; l = NSEC - 1; end
        if (f == 0 && l == NSEC - 1) begin
            expq.push_back(9'h006); expq.push_back(9'h100);
            expq.push_back(9'h0C7); expq.push_back(9'h100);
            b = (k < plan_q.size()) ? plan_q[k] : 0; k++;
            push_stat(b, CP);
            if (b < CP) return;
        end
        for (int i = f; i <= l; i++) begin
            expq.push_back(9'h006); expq.push_back(9'h100);
            a = i * SB;
            expq.push_back(9'h020);
            expq.push_back({1'b0, 8'((a >> 16) & 255)});
            expq.push_back({1'b0, 8'((a >> 8) & 255)});
            expq.push_back({1'b0, 8'(a & 255)});
            expq.push_back(9'h100);
            b = (k < plan_q.size()) ? plan_q[k] : 0; k++;
            push_stat(b, SP);
            if (b >= SP) begin e_err = 1; return; end
        end
    endtask

    task automatic run_op(input string rq, input bit whole, input int f, input int l,
                          input int gap, input bit extra);
        bit e_err;
        int cyc;
        int n;
        build_exp(whole, f, l, e_err);
        busy_plan = plan_q;
        obs.delete();
        poll_gap_i = 16'(gap);
        cur_gap = gap;
        @(negedge clk);
        whole_i = whole; first_i = IW'(f); last_i = IW'(l); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        cyc = 1;
        while (!done_o && cyc < 20000) begin
            if (extra && cyc == 8) begin
                whole_i = 1'b1; first_i = '0; last_i = IW'(NSEC - 1); start_i = 1'b1;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        start_i = 1'b0;
        chk(done_o, rq, "done seen", int'(done_o), 1);
        chk(err_o == e_err, rq, "error result", int'(err_o), int'(e_err));
        if (!whole && (l < f || l >= NSEC))
            chk(cyc == 1, "R10", "reject latency", cyc, 1);
        repeat (3) @(negedge clk);
        chk(obs.size() == expq.size(), rq, "frame stream length", obs.size(), expq.size());
        n = (obs.size() < expq.size()) ? obs.size() : expq.size();
        for (int i = 0; i < n; i++)
            chk(obs[i] == expq[i], rq, $sformatf("stream item %0d", i), int'(obs[i]), int'(expq[i]));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: quiet outputs in reset
        chk(!spi_cs_o && !spi_req_o && !done_o && !err_o, "R1", "outputs in reset",
            {spi_cs_o, spi_req_o, done_o, err_o}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!spi_cs_o && !spi_req_o && !done_o && !err_o, "R1", "outputs after reset",
            {spi_cs_o, spi_req_o, done_o, err_o}, 0);

        // R2 R3 R5: one mid-range sector, two busy polls
        plan_q = {2};
        run_op("R3", 0, 3, 3, 3, 0);
        // R9: ascending range with mixed busy counts, R6 with zero gap
        plan_q = {0, 1, 3};
        run_op("R9", 0, 2, 4, 0, 0);
        // R4: full range picks chip erase, which succeeds
        plan_q = {4};
        run_op("R4", 0, 0, NSEC - 1, 2, 0);
        // R8 R13: whole flag with junk range, chip erase times out, sectors follow
        plan_q = {CP};
        run_op("R8", 1, 5, 2, 1, 0);
        // R13: whole flag with junk range and quick chip erase
        plan_q = {0};
        run_op("R13", 1, 6, 1, 1, 0);
        // R7: sector budget exhausted in mid-range
        plan_q = {0, SP, 0};
        run_op("R7", 0, 1, 3, 1, 0);
        // R10: malformed ranges
        plan_q.delete();
        run_op("R10", 0, 4, 2, 1, 0);
        run_op("R10", 0, 0, NSEC, 1, 0);
        // R12: a second start during a request is ignored
        plan_q = {3};
        run_op("R12", 0, 6, 6, 2, 1);
        // R2: last sector alone after the ignored start
        plan_q = {0};
        run_op("R2", 0, NSEC - 1, NSEC - 1, 0, 0);
        finish_run();
    end

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        finish_run();
    end
endmodule